// File: doc/BRIEF.md
# Three-Bank Level Interrupt Aggregator

This block gathers level-sensitive interrupt requests from three groups of sources and merges them into a single interrupt line toward the CPU. Each group, called a bank, has a pending-request register and an enable-gating mask register. Software reaches both through a small 32-bit register bus with separate read and write strobes.

The first bank is 9 bits wide and serves local peripherals: bits 0 to 3 are four timers, bit 4 GPIO, bit 5 UART, bit 6 a software request, bit 7 memory-clock-ready and bit 8 PCI-clock-stopped. The second bank is 16 bits wide and carries serial IRQ lines. The third bank is 15 bits wide. In it, bit 0 is audio, bit 1 USB, bit 2 chaining DMA and bit 3 serial IOCHK. Bits 4 to 7 are serial INTA to INTD and bits 8 to 11 are PCI INTA to INTD. Bit 12 is bridge master abort, bit 13 bridge target abort and bit 14 PCI SERR.

A handler reads the pending registers and then writes back the inverse of what it read. This clears exactly the requests it has seen. The line stays asserted while any unmasked request remains anywhere.

Top module: `tri_bank_irq`

## Requirements
- R1: Register offsets on `reg_addr` are as follows. The local bank has its pending register at 0x300 and its mask at 0x308. The serial bank uses 0x320 and 0x328. The device bank uses 0x340 and 0x348. A read strobe in one cycle presents the register value on `reg_rdata` after the next rising clock edge.
- R2: After reset all pending bits are 0, every implemented mask bit is 1 (reads 0x1FF, 0xFFFF, 0x7FFF) and `irq_out` is low.
- R3: A write to a mask register stores the written bits. A mask bit of 1 blocks its source from `irq_out`, and a mask bit of 0 lets it through.
- R4: A source input that is high at a clock edge sets its pending bit, whatever the mask holds.
- R5: A write to a pending register clears each bit written as 0 and keeps each bit written as 1. A pending bit is otherwise kept until it is cleared.
- R6: If a source is still high, or rises in the same cycle as a clearing write to its bit, the bit is set after that edge. The set wins over the clear.
- R7: `irq_out` is high exactly when some bank has a pending bit whose mask bit is 0. It drops only when that holds for no bank.
- R8: Bits above each bank's width (9, 16, 15) read as 0, and writes to them have no effect.
- R9: A read of any other offset returns 0. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_src | input | 9 | Local peripheral request levels |
| ser_src | input | 16 | Serial IRQ request levels |
| dev_src | input | 15 | PCI and on-chip device request levels |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_out | output | 1 | Combined interrupt to the CPU |

## Verification
The hardest case to reach is a clearing write that lands on a bit in the same cycle as its source is high. It matters in two forms: a source that stays high through the acknowledge, and one that rises on exactly that edge. Random traffic seldom lines these up on the right bit. The stimulus therefore holds chosen source bits high, or raises them, in the cycle of an all-zero write to their bank, then reads the bank back. The random phase drives sparse source pulses together with writes of random, inverted-readback and all-zero data. This mix makes unmasked pending sets across banks empty and refill often, so `irq_out` falls and rises many times.

// File: rtl/tri_bank_irq.sv
module tri_bank_irq #(
  parameter int LOC_W  = 9,
  parameter int SER_W  = 16,
  parameter int DEV_W  = 15,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BASE   = 'h300,
  parameter int STRIDE = 'h20,
  parameter int MSK_OFS = 'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOC_W-1:0]  loc_src,
  input  logic [SER_W-1:0]  ser_src,
  input  logic [DEV_W-1:0]  dev_src,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  localparam int NB = 3;

  function automatic logic [DATA_W-1:0] width_mask(input int b);
    int w;
    w = (b == 0) ? LOC_W : (b == 1) ? SER_W : DEV_W;
    return {DATA_W{1'b1}} >> (DATA_W - w);
  endfunction

  logic [NB-1:0][DATA_W-1:0] src_v, req_q, msk_q;
  logic [NB-1:0]             pend, hit_req, hit_msk;
  logic [DATA_W-1:0]         rd_mux;
  logic                      mapped;

  assign src_v[0] = DATA_W'(loc_src);
  assign src_v[1] = DATA_W'(ser_src);
  assign src_v[2] = DATA_W'(dev_src);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [DATA_W-1:0] WM = width_mask(b);
    localparam logic [ADDR_W-1:0] A_REQ = ADDR_W'(BASE + b * STRIDE);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(BASE + b * STRIDE + MSK_OFS);

    assign hit_req[b] = reg_wr && reg_addr == A_REQ;
    assign hit_msk[b] = reg_wr && reg_addr == A_MSK;
    assign pend[b]    = |(req_q[b] & ~msk_q[b]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_q[b] <= '0;
        msk_q[b] <= WM;
      end else begin
        req_q[b] <= ((req_q[b] & (hit_req[b] ? reg_wdata : '1)) | src_v[b]) & WM;
        if (hit_msk[b]) msk_q[b] <= reg_wdata & WM;
      end
    end

    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_v[b]) |=> ((req_q[b] & $past(src_v[b])) == $past(src_v[b])));
    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_req[b] |=> ((req_q[b] & $past(req_q[b])) == $past(req_q[b])));
    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_msk[b] |=> $stable(msk_q[b]));
  end

  always_comb begin
    rd_mux = '0;
    mapped = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == ADDR_W'(BASE + b * STRIDE)) begin
        rd_mux = req_q[b];
        mapped = 1'b1;
      end
      if (reg_addr == ADDR_W'(BASE + b * STRIDE + MSK_OFS)) begin
        rd_mux = msk_q[b];
        mapped = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= reg_rd ? rd_mux : '0;
  end

  assign irq_out = |pend;

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !reg_wr) |=> irq_out);
  p_rd_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !mapped) |=> (reg_rdata == '0));
endmodule

// File: tb/tri_bank_irq_bench.sv
module tri_bank_irq_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [8:0]  loc_src = 0;
  logic [15:0] ser_src = 0;
  logic [14:0] dev_src = 0;
  logic [11:0] reg_addr = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int total = 0, bad = 0;
  logic [31:0] m_req [3];
  logic [31:0] m_msk [3];

  always #2 clk = ~clk;

  tri_bank_irq u_tri_bank_irq (.*);

  function automatic logic [31:0] wm(input int b);
    return b == 0 ? 32'h1FF : b == 1 ? 32'hFFFF : 32'h7FFF;
  endfunction

  function automatic logic [11:0] adr(input int b, input bit msk);
    return 12'h300 + 12'(b * 'h20) + (msk ? 12'h8 : 12'h0);
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    for (int b = 0; b < 3; b++) begin
      if (a == adr(b, 0)) return m_req[b];
      if (a == adr(b, 1)) return m_msk[b];
    end
    return 0;
  endfunction

  function automatic bit model_irq();
    for (int b = 0; b < 3; b++) if ((m_req[b] & ~m_msk[b]) != 0) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model the edge, check after it
  task automatic cyc(input logic [8:0] ls, input logic [15:0] ss, input logic [14:0] ds,
                     input bit rd, input bit wr, input logic [11:0] a,
                     input logic [31:0] wd, input string tag);
    logic [31:0] exp_rd;
    logic [31:0] s [3];
    loc_src = ls; ser_src = ss; dev_src = ds;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    exp_rd = rd ? model_read(a) : 0;
    s[0] = 32'(ls); s[1] = 32'(ss); s[2] = 32'(ds);
    for (int b = 0; b < 3; b++) begin
      logic [31:0] k;
      k = (wr && a == adr(b, 0)) ? wd : 32'hFFFF_FFFF;
      m_req[b] = ((m_req[b] & k) | s[b]) & wm(b);
      if (wr && a == adr(b, 1)) m_msk[b] = wd & wm(b);
    end
    @(negedge clk);
    check("R7 irq", 32'(irq_out), 32'(model_irq()));
    if (rd) check(tag, reg_rdata, exp_rd);
  endtask

  task automatic rd_chk(input logic [11:0] a, input string tag);
    cyc(0, 0, 0, 1, 0, a, 0, tag);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < 3; b++) begin m_req[b] = 0; m_msk[b] = wm(b); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    check("R2 irq reset", 32'(irq_out), 0);
    for (int b = 0; b < 3; b++) begin
      rd_chk(adr(b, 0), "R2 req reset");
      rd_chk(adr(b, 1), "R2 mask reset");
    end
    // R4: masked source still latched, no irq
    cyc(9'h004, 0, 0, 0, 0, 0, 0, "");
    rd_chk(adr(0, 0), "R4 masked latch");
    check("R3 masked no irq", 32'(irq_out), 0);
    // R3: unmask bit 2 raises irq
    cyc(0, 0, 0, 0, 1, adr(0, 1), 32'hFFFF_FFFB, "");
    check("R3 unmask irq", 32'(irq_out), 1);
    // R8: upper bits ignored
    rd_chk(adr(0, 1), "R8 mask width");
    cyc(0, 0, 0, 0, 1, adr(2, 1), 32'hFFFF_0000, "");
    rd_chk(adr(2, 1), "R8 dev mask width");
    // R9: unmapped write and read
    cyc(0, 0, 0, 0, 1, 12'h304, 32'h0, "");
    rd_chk(adr(0, 0), "R9 unmapped write");
    rd_chk(12'h304, "R9 unmapped read");
    rd_chk(12'h34C, "R9 unmapped read");
    // R5: write-one keeps, write-zero clears
    cyc(0, 16'h0011, 0, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 1, adr(1, 0), 32'hFFFF_FFEF, "");
    rd_chk(adr(1, 0), "R5 partial clear");
    // R6: source held during clear
    cyc(0, 0, 15'h4000, 0, 0, 0, 0, "");
    cyc(0, 0, 15'h4000, 0, 1, adr(2, 0), 0, "");
    rd_chk(adr(2, 0), "R6 held source re-sets");
    // R6: source rising on the clearing edge
    cyc(0, 0, 15'h0100, 0, 1, adr(2, 0), 0, "");
    rd_chk(adr(2, 0), "R6 set wins");
    // R7: clear all banks, irq low
    for (int b = 0; b < 3; b++) cyc(0, 0, 0, 0, 1, adr(b, 0), 0, "");
    check("R7 all clear", 32'(irq_out), 0);
    // R1: random traffic with read-back
    for (int i = 0; i < 3000; i++) begin
      int b, op;
      logic [31:0] wd;
      logic [8:0] ls; logic [15:0] ss; logic [14:0] ds;
      b = $urandom_range(0, 2);
      op = $urandom_range(0, 9);
      ls = ($urandom_range(0, 3) == 0) ? 9'(1 << $urandom_range(0, 8)) : 0;
      ss = ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : 0;
      ds = ($urandom_range(0, 3) == 0) ? 15'(1 << $urandom_range(0, 14)) : 0;
      case (op)
        0, 1, 2, 3: cyc(ls, ss, ds, 1, 0, adr(b, $urandom_range(0, 1)), 0, "R1 read");
        4: cyc(ls, ss, ds, 0, 1, adr(b, 0), ~model_read(adr(b, 0)), "");
        5: cyc(ls, ss, ds, 0, 1, adr(b, 0), 0, "");
        6: cyc(ls, ss, ds, 0, 1, adr(b, 1), $urandom(), "");
        7: cyc(ls, ss, ds, 0, 1, adr(b, 0), $urandom(), "");
        8: begin
          wd = $urandom();
          cyc(ls, ss, ds, 1, 1, 12'($urandom_range(0, 4095)), wd, "R9 random addr");
        end
        default: cyc(ls, ss, ds, 0, 0, 0, 0, "");
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule